// File: doc/BRIEF.md
# Disk Change Status Latch

This block keeps the single status flag that tells software the removable medium in a drive may have been swapped. The flag is set by reset, by an eject event, by an insert event, and for as long as the drive reports no medium. The only event that clears it is a step of the head to a different cylinder while a medium is present. A step that leaves the head on its current cylinder does not clear it.

Software sees the flag as the most significant bit of an 8-bit input status byte. A read strobe captures that byte into a holding register, and the byte appears there one cycle after the strobe. Reading does not change the flag, so the flag can be polled any number of times. The seek logic supplies a one-cycle step pulse together with a qualifier that says whether the present cylinder actually changed.

Top module: `disk_change_latch`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the flag output reads 1.
- R2: A read strobe loads the status byte on the next clock edge. The flag sits in bit 7 (0x80 when set, 0x00 when clear) and bits 6:0 read 0.
- R3: A read strobe never changes the flag.
- R4: An insert event sets the flag on the next edge. The flag stays set until a qualifying step occurs.
- R5: A step pulse with the moved qualifier low leaves the flag unchanged.
- R6: A step pulse with the moved qualifier high, while the medium is present and no eject or insert occurs in that cycle, clears the flag on the next edge.
- R7: An eject event sets the flag on the next edge.
- R8: While the medium-present input is low, the flag is held at 1 whatever steps arrive.
- R9: When an insert event and a qualifying step fall in the same cycle, the insert wins and the flag is 1 afterwards.
- R10: Once the flag is clear, it stays clear until an eject, an insert or a loss of medium occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| media_in | input | 1 | Level: a medium is in the drive |
| eject_ev | input | 1 | One-cycle eject event |
| insert_ev | input | 1 | One-cycle insert event |
| step_ev | input | 1 | One-cycle step pulse from the seek logic |
| step_moved | input | 1 | Qualifies step_ev: the cylinder changed |
| rd_en | input | 1 | Status-byte read strobe |
| chg_flag | output | 1 | Latched disk-change flag |
| rd_byte | output | 8 | Captured status byte, flag in bit 7 |

## Verification
The flag is driven through several kinds of step. Steps to the same cylinder with a medium present must leave the flag set, which separates a clear on any step from a clear on a real move. Moving steps while the drive is empty must also leave it set, which separates a design that ignores medium presence. Bursts of reads with the flag set and with it clear show that reading has no side effect and that the flag sits in bit 7 only. An insert that coincides with a moving step checks the priority rule, and an eject followed by moving steps shows that the flag sets again and stays set.

// File: rtl/disk_change_latch.sv
module disk_change_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       media_in,
  input  logic       eject_ev,
  input  logic       insert_ev,
  input  logic       step_ev,
  input  logic       step_moved,
  input  logic       rd_en,
  output logic       chg_flag,
  output logic [7:0] rd_byte
);

  logic set_cond;
  logic clr_cond;

  assign set_cond = !media_in || eject_ev || insert_ev;
  assign clr_cond = step_ev && step_moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chg_flag <= 1'b1;
    else if (set_cond) chg_flag <= 1'b1;
    else if (clr_cond) chg_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_byte <= 8'h00;
    else if (rd_en) rd_byte <= {chg_flag, 7'b0};
  end

  assert_read_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_byte == {$past(chg_flag), 7'b0}));

  assert_read_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte[6:0] == 7'b0);

  assert_insert_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    insert_ev |=> chg_flag);

  assert_no_move_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (media_in && !eject_ev && !insert_ev && !(step_ev && step_moved)) |=> $stable(chg_flag));

  assert_move_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (media_in && !eject_ev && !insert_ev && step_ev && step_moved) |=> !chg_flag);

  assert_eject_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eject_ev |=> chg_flag);

  assert_empty_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !media_in |=> chg_flag);

  assert_clear_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_flag && media_in && !eject_ev && !insert_ev) |=> !chg_flag);

endmodule

// File: tb/sim_disk_change_latch.sv
module sim_disk_change_latch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       media_in = 1'b0;
  logic       eject_ev = 1'b0;
  logic       insert_ev = 1'b0;
  logic       step_ev = 1'b0;
  logic       step_moved = 1'b0;
  logic       rd_en = 1'b0;
  logic       chg_flag;
  logic [7:0] rd_byte;

  always #5 clk = ~clk;

  disk_change_latch u0 (
    .clk(clk), .rst_n(rst_n), .media_in(media_in), .eject_ev(eject_ev),
    .insert_ev(insert_ev), .step_ev(step_ev), .step_moved(step_moved),
    .rd_en(rd_en), .chg_flag(chg_flag), .rd_byte(rd_byte)
  );

  typedef struct {
    logic       flag;
    logic [7:0] byte_v;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_bad  = 0;
  logic ref_flag = 1'b1;
  logic [7:0] ref_byte = 8'h00;
  bit   done = 0;

  task automatic apply(input logic med, input logic ej, input logic ins,
                       input logic st, input logic mv, input logic rd,
                       input string tag);
    exp_t e;
    @(negedge clk);
    media_in = med; eject_ev = ej; insert_ev = ins;
    step_ev = st; step_moved = mv; rd_en = rd;
    if (rd) ref_byte = {ref_flag, 7'b0};
    if (!med || ej || ins) ref_flag = 1'b1;
    else if (st && mv)     ref_flag = 1'b0;
    e.flag = ref_flag; e.byte_v = ref_byte; e.tag = tag;
    @(posedge clk);
    #1 exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (chg_flag !== e.flag || rd_byte !== e.byte_v) begin
        n_bad++;
        $display("FAIL %s: flag=%b byte=%02h expected flag=%b byte=%02h",
                 e.tag, chg_flag, rd_byte, e.flag, e.byte_v);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (chg_flag !== 1'b1 || rd_byte !== 8'h00) begin
      n_bad++;
      $display("FAIL R1: flag=%b byte=%02h expected flag=1 byte=00", chg_flag, rd_byte);
    end
    @(negedge clk);
    rst_n = 1'b1;
    apply(0,0,0,0,0,0, "R1");
    // repeated reads with the drive empty
    for (int i = 0; i < 4; i++) apply(0,0,0,0,0,1, "R2/R3 empty read");
    // moving steps while empty
    for (int i = 0; i < 3; i++) apply(0,0,0,1,1,0, "R8");
    apply(0,0,0,0,0,1, "R8 read");
    // insert medium
    apply(1,0,1,0,0,0, "R4");
    apply(1,0,0,0,0,1, "R4 read");
    // same-cylinder steps
    for (int i = 0; i < 3; i++) apply(1,0,0,1,0,0, "R5");
    apply(1,0,0,0,0,1, "R5 read");
    // real move clears
    apply(1,0,0,1,1,0, "R6");
    for (int i = 0; i < 3; i++) apply(1,0,0,0,0,1, "R2/R3 clear read");
    for (int i = 0; i < 4; i++) apply(1,0,0,1,(i%2==1),0, "R10");
    // eject
    apply(0,1,0,0,0,0, "R7");
    apply(0,0,0,0,0,1, "R7 read");
    apply(0,0,0,1,0,0, "R8 same cyl");
    apply(0,0,0,1,1,0, "R8 moved");
    // insert coinciding with a moving step
    apply(1,0,1,1,1,0, "R9");
    apply(1,0,0,0,0,1, "R9 read");
    apply(1,0,0,1,1,1, "R6 again");
    apply(1,0,0,0,0,1, "R2 after clear");
    // eject while present still high for one cycle, with a move
    apply(1,1,0,1,1,0, "R7 priority");
    apply(1,0,0,0,0,0, "R4 hold");
    apply(1,0,0,1,1,0, "R6 final");
    apply(1,0,0,0,0,0, "R10 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule